// File: doc/BRIEF.md
# Two-Channel Down-Counting Interval Timer

This block provides two independent 16-bit down-counters, addressed as channel 0 and channel 2, behind a byte-wide write interface. A control word written to the control port picks a channel and its operating mode. A pair of byte writes to that channel's data port then loads a count and starts it. Each counter decrements once for every cycle in which the `tick` enable is high. `tick` stands for the slow counter input clock, nominally 1,193,180 Hz, so one period lasts the count multiplied by that input period.

In one-shot mode (mode 0) a channel stops when it reaches terminal count and raises a done flag. In every other mode it reloads its count and runs again. Every terminal count gives a one-cycle pulse on that channel's `expire` bit. The status output shows the done flag of channel 2 as bit 5 (value 0x20). A control word that asks for an unsupported access pattern or channel is rejected with a one-cycle `cfg_err` pulse.

Top module: `pit_timer`

## Requirements
- R1: After reset, `rd_status` is 0x00, `cfg_err` is 0 and `expire` is 00. Both channels are idle.
- R2: A write to port 0 (control) is accepted when bits 5:4 are 11. Bits 7:6 pick the channel (00 = channel 0, 10 = channel 2), bits 3:1 give the mode and bit 0 is ignored. An accepted word gives `cfg_err` = 0.
- R3: A control write whose bits 5:4 are not 11 pulses `cfg_err` high for exactly one cycle and leaves every channel's mode unchanged.
- R4: A control write whose bits 7:6 are 11 (read-back) or 01 pulses `cfg_err` for one cycle and changes nothing.
- R5: Data writes go to port 1 for channel 0 and port 2 for channel 2. One first-byte flag is shared by both ports. The first write stores the low byte and sets the flag. The next write to either port supplies the high byte, loads {high, low} into the channel addressed by that second write, starts it and clears the flag.
- R6: Starting a channel clears its done flag, so for channel 2 `rd_status` reads 0x00 right after the start.
- R7: In mode 0, a loaded count N gives exactly one `expire` pulse, on the Nth tick. From then on the channel's done flag is set (0x20 for channel 2) and the channel stops counting.
- R8: In any mode other than 0, a count N gives an `expire` pulse every N ticks, and the done flag stays clear.
- R9: A loaded count of 0 counts 65536 ticks.
- R10: Counters advance only in cycles where `tick` is 1. With `tick` low, no count progresses and no `expire` pulse occurs.
- R11: `rd_status` reflects channel 2 only. The done flag of channel 0 never appears on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_port | input | 2 | Target port: 0 control, 1 channel 0 data, 2 channel 2 data, 3 none |
| wr_data | input | 8 | Write byte |
| tick | input | 1 | Counter input clock enable, one count per high cycle |
| rd_status | output | 8 | Channel 2 status byte, 0x20 when its one-shot is done |
| cfg_err | output | 1 | One-cycle pulse after a rejected control word |
| expire | output | 2 | Terminal-count pulses: bit 0 channel 0, bit 1 channel 2 |

## Verification
The properties assume `wr_port` is only meaningful while `wr_en` is high. They also assume a start on a channel always wins over a `tick` in the same cycle. The bench therefore holds `tick` low while it writes, and it only pulses `tick` between write sequences. Every data write is issued in low/high pairs, so the shared first-byte flag is always clear when a new sequence starts. The single exception is the deliberate cross-port pair. Expected tick indices of each pulse are computed as multiples of the loaded count.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int BYTE_W   = 8;
   localparam int MODE_W   = 3;
   localparam int DONE_BIT = 5;

   typedef enum logic [1:0] {
      PORT_CTRL  = 2'd0,
      PORT_DATA0 = 2'd1,
      PORT_DATA2 = 2'd2,
      PORT_IDLE  = 2'd3
   } pit_port_e;

   localparam logic [1:0] ACC_LOHI = 2'b11;
   localparam logic [1:0] SEL_CH0  = 2'b00;
   localparam logic [1:0] SEL_CH2  = 2'b10;

   typedef struct packed {
      logic [1:0]        sel;
      logic [1:0]        acc;
      logic [MODE_W-1:0] mode;
      logic              fmt;
   } pit_ctrl_t;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
   import pit_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_port,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [NUM_CH-1:0]   mode_we,
   output logic [MODE_W-1:0]   mode_val,
   output logic [NUM_CH-1:0]   load_we,
   output logic [2*BYTE_W-1:0] load_val,
   output logic                cfg_err,
   output logic                first_q
);
   localparam int LOAD_W = 2 * BYTE_W;

   pit_ctrl_t         cw;
   pit_port_e         port;
   logic              is_ctrl, is_data, acc_ok, sel_ok, bad;
   logic              data_idx;
   logic [BYTE_W-1:0] low_q;
   logic              err_q;

   always_comb begin
      port     = pit_port_e'(wr_port);
      cw       = pit_ctrl_t'(wr_data);
      is_ctrl  = wr_en && (port == PORT_CTRL);
      is_data  = wr_en && ((port == PORT_DATA0) || (port == PORT_DATA2));
      data_idx = (port == PORT_DATA2);
      acc_ok   = (cw.acc == ACC_LOHI);
      sel_ok   = (cw.sel == SEL_CH0) || (cw.sel == SEL_CH2);
      bad      = is_ctrl && !(acc_ok && sel_ok);
      mode_we  = '0;
      mode_we[0] = is_ctrl && acc_ok && (cw.sel == SEL_CH0);
      mode_we[NUM_CH-1] = is_ctrl && acc_ok && (cw.sel == SEL_CH2);
      mode_val = cw.mode;
      load_we  = '0;
      load_we[0] = is_data && first_q && !data_idx;
      load_we[NUM_CH-1] = is_data && first_q && data_idx;
      load_val = LOAD_W'({wr_data, low_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         low_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= bad;
         if (is_data) begin
            if (first_q) begin
               first_q <= 1'b0;
            end else begin
               first_q <= 1'b1;
               low_q   <= wr_data;
            end
         end
      end
   end

   assign cfg_err = err_q;
endmodule

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              load_we,
   input  logic [CNT_W-1:0]  load_val,
   output logic              expire,
   output logic              done
);
   localparam int FULL_W = CNT_W + 1;

   logic [FULL_W-1:0] full_load;
   logic [FULL_W-1:0] cnt_q, reload_q;
   logic [MODE_W-1:0] mode_q;
   logic              run_q, done_q, exp_q;
   logic              at_end, one_shot;

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign full_load = (load_val == '0) ? (FULL_W'(1) << CNT_W)
                                             : FULL_W'(load_val);
      end else begin : g_zero_one
         assign full_load = (load_val == '0) ? FULL_W'(1)
                                             : FULL_W'(load_val);
      end
   endgenerate

   assign at_end   = (cnt_q == FULL_W'(1));
   assign one_shot = (mode_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
         mode_q   <= '0;
         run_q    <= 1'b0;
         done_q   <= 1'b0;
         exp_q    <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (mode_we) mode_q <= mode_in;
         if (load_we) begin
            cnt_q    <= full_load;
            reload_q <= full_load;
            run_q    <= 1'b1;
            done_q   <= 1'b0;
         end else if (run_q && tick) begin
            if (at_end) begin
               exp_q <= 1'b1;
               if (one_shot) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= reload_q;
               end
            end else begin
               cnt_q <= cnt_q - FULL_W'(1);
            end
         end
      end
   end

   assign expire = exp_q;
   assign done   = done_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_port,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              tick,
   output logic [BYTE_W-1:0] rd_status,
   output logic              cfg_err,
   output logic [1:0]        expire
);
   localparam int NUM_CH = 2;
   localparam int LOAD_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] DONE_BYTE = BYTE_W'(1) << DONE_BIT;

   generate
      if (CNT_W != LOAD_W) begin : g_bad_width
         $error("pit_timer: CNT_W must equal two data bytes");
      end
      if (DONE_BIT >= BYTE_W) begin : g_bad_bit
         $error("pit_timer: status bit outside the byte");
      end
   endgenerate

   logic [NUM_CH-1:0] mode_we, load_we, ch_done, ch_exp;
   logic [MODE_W-1:0] mode_val;
   logic [LOAD_W-1:0] load_val;
   logic              seq_first;

   pit_ctrl_decode #(.NUM_CH(NUM_CH)) i_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_port  (wr_port),
      .wr_data  (wr_data),
      .mode_we  (mode_we),
      .mode_val (mode_val),
      .load_we  (load_we),
      .load_val (load_val),
      .cfg_err  (cfg_err),
      .first_q  (seq_first)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pit_counter #(.CNT_W(CNT_W), .ZERO_IS_MAX(ZERO_IS_MAX)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .mode_we  (mode_we[c]),
            .mode_in  (mode_val),
            .load_we  (load_we[c]),
            .load_val (CNT_W'(load_val)),
            .expire   (ch_exp[c]),
            .done     (ch_done[c])
         );
      end
   endgenerate

   assign expire    = ch_exp;
   assign rd_status = ch_done[NUM_CH-1] ? DONE_BYTE : '0;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_port,
   input logic [7:0] wr_data,
   input logic       tick,
   input logic [7:0] rd_status,
   input logic       cfg_err,
   input logic [1:0] expire,
   input logic       first_q
);
   logic ctrl_wr, start2;
   assign ctrl_wr = wr_en && (wr_port == 2'd0);
   assign start2  = wr_en && (wr_port == 2'd2) && first_q;

   a_r3_bad_access_err: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && (wr_data[5:4] != 2'b11) |=> cfg_err);

   a_r4_bad_channel_err: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && (wr_data[6] == 1'b1) |=> cfg_err);

   a_r2_good_word_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && (wr_data[5:4] == 2'b11) && (wr_data[6] == 1'b0) |=> !cfg_err);

   a_r3_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> !cfg_err);

   a_r10_no_tick_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (expire == 2'b00));

   a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start2 |=> (rd_status == 8'h00));

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status == 8'h20) && !start2 |=> (rd_status == 8'h20));

   a_r11_status_values: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status == 8'h00) || (rd_status == 8'h20));
endmodule

bind pit_timer pit_timer_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_port   (wr_port),
   .wr_data   (wr_data),
   .tick      (tick),
   .rd_status (rd_status),
   .cfg_err   (cfg_err),
   .expire    (expire),
   .first_q   (seq_first)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_port = 2'd3;
   logic [7:0] wr_data = 8'h00;
   logic       tick = 1'b0;
   logic [7:0] rd_status;
   logic       cfg_err;
   logic [1:0] expire;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pit_timer i_pit_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
      .wr_data(wr_data), .tick(tick), .rd_status(rd_status),
      .cfg_err(cfg_err), .expire(expire)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] p, input logic [7:0] d, output logic err);
      @(negedge clk);
      wr_en = 1'b1; wr_port = p; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_port = 2'd3;
      err = cfg_err;
   endtask

   task automatic prog(input logic [1:0] p, input int cnt);
      logic e;
      wr(p, 8'(cnt), e);
      wr(p, 8'(cnt >> 8), e);
   endtask

   task automatic run(input int n, output int c0, output int c2, output int f2);
      c0 = 0; c2 = 0; f2 = 0;
      for (int k = 0; k <= n; k++) begin
         @(negedge clk);
         if (k > 0) begin
            if (expire[0]) c0++;
            if (expire[1]) begin
               c2++;
               if (f2 == 0) f2 = k;
            end
         end
         tick = (k < n);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic e;
      int c0, c2, f2;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_status == 8'h00, "R1 status", rd_status, 0);
      chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);
      chk(expire == 2'b00, "R1 expire", expire, 0);
      rst_n = 1'b1;
      run(5, c0, c2, f2);
      chk(c0 + c2 == 0, "R1 idle", c0 + c2, 0);

      // R2 channel 2 mode 0, then R7 one-shot count 5
      wr(2'd0, 8'hB0, e);
      chk(e == 1'b0, "R2 accept", e, 0);
      @(negedge clk);
      chk(cfg_err == 1'b0, "R2 err stays low", cfg_err, 0);
      prog(2'd2, 5);
      chk(rd_status == 8'h00, "R6 status after start", rd_status, 0);
      run(4, c0, c2, f2);
      chk(c2 == 0 && rd_status == 8'h00, "R7 before end", c2, 0);
      run(6, c0, c2, f2);
      chk(c2 == 1 && f2 == 1, "R7 pulse on tick 5", f2, 1);
      chk(rd_status == 8'h20, "R7 done", rd_status, 32);

      // R6 restart clears, one-shot of 3
      prog(2'd2, 3);
      chk(rd_status == 8'h00, "R6 restart clears", rd_status, 0);
      run(8, c0, c2, f2);
      chk(c2 == 1 && f2 == 3, "R7 single pulse", c2 * 100 + f2, 103);

      // R8 periodic mode 2, count 4
      wr(2'd0, 8'hB4, e);
      prog(2'd2, 4);
      run(12, c0, c2, f2);
      chk(c2 == 3 && f2 == 4, "R8 periodic", c2 * 100 + f2, 304);
      chk(rd_status == 8'h00, "R8 no done", rd_status, 0);

      // R3 bad access mode rejected, mode stays periodic
      wr(2'd0, 8'h90, e);
      chk(e == 1'b1, "R3 err pulse", e, 1);
      @(negedge clk);
      chk(cfg_err == 1'b0, "R3 one cycle", cfg_err, 0);
      prog(2'd2, 2);
      run(7, c0, c2, f2);
      chk(c2 == 3, "R3 mode unchanged", c2, 3);

      // R4 read-back and channel 1 rejected
      wr(2'd0, 8'hF0, e);
      chk(e == 1'b1, "R4 readback err", e, 1);
      wr(2'd0, 8'h70, e);
      chk(e == 1'b1, "R4 channel1 err", e, 1);
      prog(2'd2, 2);
      run(4, c0, c2, f2);
      chk(c2 == 2, "R4 no change", c2, 2);

      // R8 on channel 0, periodic count 3
      wr(2'd0, 8'h34, e);
      prog(2'd1, 3);
      run(9, c0, c2, f2);
      chk(c0 == 3, "R8 ch0 periodic", c0, 3);

      // R11 channel 0 one-shot does not show on status
      wr(2'd0, 8'h30, e);
      prog(2'd1, 2);
      run(4, c0, c2, f2);
      chk(c0 == 1, "R7 ch0 one-shot", c0, 1);
      chk(rd_status == 8'h00, "R11 ch0 hidden", rd_status, 0);

      // R5 shared first-byte flag across ports
      wr(2'd0, 8'hB0, e);
      wr(2'd1, 8'h03, e);
      wr(2'd2, 8'h00, e);
      run(5, c0, c2, f2);
      chk(c2 == 1 && f2 == 3, "R5 cross-port load", f2, 3);
      chk(c0 == 0, "R5 ch0 untouched", c0, 0);
      chk(rd_status == 8'h20, "R5 ch2 done", rd_status, 32);

      // R10 no count without tick
      prog(2'd2, 2);
      repeat (10) @(negedge clk);
      chk(rd_status == 8'h00 && expire == 2'b00, "R10 held", rd_status, 0);
      run(2, c0, c2, f2);
      chk(c2 == 1 && f2 == 2, "R10 resumes", f2, 2);

      // R5 high byte order: 0x0102 = 258 ticks
      prog(2'd2, 258);
      run(300, c0, c2, f2);
      chk(c2 == 1 && f2 == 258, "R5 high byte", f2, 258);

      // R9 count zero means 65536
      prog(2'd2, 0);
      run(65535, c0, c2, f2);
      chk(c2 == 0 && rd_status == 8'h00, "R9 not yet", c2, 0);
      run(1, c0, c2, f2);
      chk(c2 == 1 && rd_status == 8'h20, "R9 at 65536", c2, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule